// File: doc/BRIEF.md
# Cache Output Sequencer with Paired Read and Refill Machines

This block sits at the tail of a two-way read-only pixel cache. It takes one entry at a time from the cache's output-request queue and returns the requested 16-bit pixel together with the entry's client ID. Two separate state machines work on each entry. The read machine fetches the pixel from the line store. The refill machine, which acts only on misses, takes the 256-bit line from the refill queue and writes it into the line store as two 128-bit halves. The two machines meet in a shared sync state, and the queue entry is popped as they leave it together.

The line store is modelled inside the block. It takes 128-bit writes and returns 16-bit reads, and a read address yields its pixel two clocks after it is issued. Both queues appear as FIFO-style ports: an empty flag, the head data, and a pop strobe. For a miss, both machines hold the entry until refill data is present. The read therefore always sees the freshly written line, including its upper half.

Top module: `cache_out_seq`

## Requirements
- R1: During reset, and in any cycle after reset while the request queue is empty, `px_valid`, `oq_pop` and `rf_pop` stay low. A reset taken partway through an entry aborts it, and no pixel is returned for it.
- R2: A hit entry (`oq_hit`=1) at the head of a non-empty queue starts in the cycle it is first seen by an idle block. Its pixel appears with `px_valid` exactly three cycles after that start cycle.
- R3: A miss entry (`oq_hit`=0) does not start while `rf_empty` is high. In those cycles `rf_pop`, `oq_pop` and `px_valid` stay low.
- R4: `rf_pop` is high for exactly one cycle per miss, in the cycle the miss starts. It never fires for a hit, even when the refill queue is non-empty.
- R5: Pixel p (0..15, from `oq_pix`) of a line is bits [16p+15:16p] of the 256-bit refill line. The low 128 bits are stored at word {set, way, 0} and the high 128 bits at word {set, way, 1}, with `oq_set`, `oq_way` and `oq_pix` as the entry fields. A line stays in place until a later miss to the same set and way replaces it.
- R6: For a miss, the line-store write enable is high for exactly two consecutive cycles and then falls. It is never high for a hit.
- R7: `px_valid` is a one-cycle pulse, given once per entry. `px_client` carries that entry's client ID, and pixels leave in queue order.
- R8: `oq_pop` is high for exactly one cycle per entry. That cycle is the one in which both machines are in sync, and it coincides with `px_valid`. The next entry can start in the following cycle.
- R9: The environment keeps the refill queue empty whenever the request queue is empty.
- R10: The line store captures read data exactly two clocks after the read address is issued, and each machine waiting in sync stays there until its partner arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oq_empty | input | 1 | Request queue empty flag |
| oq_client | input | 2 | Head entry client ID |
| oq_hit | input | 1 | Head entry hit flag (1 = hit) |
| oq_set | input | 7 | Head entry set index |
| oq_way | input | 1 | Head entry way |
| oq_pix | input | 4 | Head entry pixel offset within the line |
| oq_pop | output | 1 | Pops the request queue head |
| rf_empty | input | 1 | Refill queue empty flag |
| rf_line | input | 256 | Refill queue head line |
| rf_pop | output | 1 | Pops the refill queue head |
| px_valid | output | 1 | Pixel valid pulse |
| px_client | output | 2 | Client ID of the returned pixel |
| px_data | output | 16 | Returned pixel |

## Verification
The start cycle of an entry is the first cycle in which it is at the queue head and can go. For a hit, that is the cycle it is first presented. For a miss, it is the cycle `rf_pop` fires.

The pixel, its client ID and `oq_pop` are all due exactly three cycles after the start cycle. The refill write enable spans the start cycle and the one after it. The bench counts cycles from the moment it presents an entry and samples a quarter period after each falling edge. It fixes the start cycle by watching `rf_pop`, then requires `px_valid` at start+3, with `oq_pop` high in that same cycle. While a miss waits for data, every cycle is checked for silence on all strobes.

// File: rtl/cos_pkg.sv
package cos_pkg;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_GAP  = 2'd1,
    RD_CAPT = 2'd2,
    RD_SYNC = 2'd3
  } rd_state_t;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_HIGH = 2'd1,
    WR_SYNC = 2'd2
  } wr_state_t;

endpackage

// File: rtl/cos_line_store.sv
module cos_line_store #(
  parameter int SET_W  = 7,
  parameter int OFF_W  = 4,
  parameter int PIX_W  = 16,
  parameter int HALF_W = 128
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [SET_W+1:0]       waddr,
  input  logic [HALF_W-1:0]      wdata,
  input  logic [SET_W+OFF_W:0]   raddr,
  input  logic                   cap,
  output logic [PIX_W-1:0]       rd_pix
);
  localparam int WADDR_W = SET_W + 2;
  localparam int RADDR_W = SET_W + 1 + OFF_W;
  localparam int DEPTH   = 1 << WADDR_W;
  localparam int LANE_W  = OFF_W - 1;

  logic [HALF_W-1:0]  mem [DEPTH];
  logic [RADDR_W-1:0] raddr_q;

  // pixel address {set, way, pix} -> half-line word {set, way, pix msb}
  function automatic logic [WADDR_W-1:0] word_of(input logic [RADDR_W-1:0] a);
    return {a[RADDR_W-1:OFF_W], a[OFF_W-1]};
  endfunction

  function automatic logic [PIX_W-1:0] lane_of(input logic [HALF_W-1:0] w,
                                               input logic [RADDR_W-1:0] a);
    logic [LANE_W-1:0] ln;
    ln = a[LANE_W-1:0];
    return w[int'(ln)*PIX_W +: PIX_W];
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    raddr_q <= raddr;
    if (cap) rd_pix <= lane_of(mem[word_of(raddr_q)], raddr_q);
  end

endmodule

// File: rtl/cos_read_fsm.sv
module cos_read_fsm
  import cos_pkg::*;
#(
  parameter int CLIENT_W = 2,
  parameter int RADDR_W  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [CLIENT_W-1:0] client_in,
  input  logic [RADDR_W-1:0]  raddr_in,
  input  logic                peer_sync,
  output logic [RADDR_W-1:0]  rd_addr,
  output logic                cap,
  output logic                px_valid,
  output logic [CLIENT_W-1:0] px_client,
  output logic                issue,
  output logic                idle,
  output logic                in_sync
);
  rd_state_t st;

  assign idle    = (st == RD_IDLE);
  assign issue   = idle && go;
  assign cap     = (st == RD_CAPT);
  assign in_sync = (st == RD_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RD_IDLE;
      rd_addr   <= '0;
      px_client <= '0;
      px_valid  <= 1'b0;
    end else begin
      px_valid <= 1'b0;
      unique case (st)
        RD_IDLE: if (go) begin
          rd_addr   <= raddr_in;
          px_client <= client_in;
          st        <= RD_GAP;
        end
        RD_GAP:  st <= RD_CAPT;
        RD_CAPT: begin
          px_valid <= 1'b1;
          st       <= RD_SYNC;
        end
        RD_SYNC: if (peer_sync) st <= RD_IDLE;
        default: st <= RD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cos_write_fsm.sv
module cos_write_fsm
  import cos_pkg::*;
#(
  parameter int SET_W  = 7,
  parameter int HALF_W = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                miss,
  input  logic [SET_W-1:0]    set_in,
  input  logic                way_in,
  input  logic [2*HALF_W-1:0] line_in,
  input  logic                peer_sync,
  output logic                we,
  output logic [SET_W+1:0]    waddr,
  output logic [HALF_W-1:0]   wdata,
  output logic                rf_pop,
  output logic                in_sync
);
  wr_state_t         st;
  logic [SET_W-1:0]  set_q;
  logic              way_q;
  logic              miss_q;
  logic [HALF_W-1:0] hi_q;

  function automatic logic [SET_W+1:0] half_addr(input logic [SET_W-1:0] s,
                                                 input logic w, input logic h);
    return {s, w, h};
  endfunction

  logic idle;
  assign idle    = (st == WR_IDLE);
  assign in_sync = (st == WR_SYNC);
  assign rf_pop  = idle && go && miss;

  always_comb begin
    if (idle) begin
      we    = go && miss;
      waddr = half_addr(set_in, way_in, 1'b0);
      wdata = line_in[HALF_W-1:0];
    end else begin
      we    = (st == WR_HIGH) && miss_q;
      waddr = half_addr(set_q, way_q, 1'b1);
      wdata = hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= WR_IDLE;
      set_q  <= '0;
      way_q  <= 1'b0;
      miss_q <= 1'b0;
      hi_q   <= '0;
    end else begin
      unique case (st)
        WR_IDLE: if (go) begin
          set_q  <= set_in;
          way_q  <= way_in;
          miss_q <= miss;
          hi_q   <= line_in[2*HALF_W-1:HALF_W];
          st     <= WR_HIGH;
        end
        WR_HIGH: st <= WR_SYNC;
        WR_SYNC: if (peer_sync) st <= WR_IDLE;
        default: st <= WR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cache_out_seq.sv
module cache_out_seq #(
  parameter int CLIENT_W     = 2,
  parameter int SET_W        = 7,
  parameter int PIX_W        = 16,
  parameter int PIX_PER_LINE = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               oq_empty,
  input  logic [CLIENT_W-1:0]                oq_client,
  input  logic                               oq_hit,
  input  logic [SET_W-1:0]                   oq_set,
  input  logic                               oq_way,
  input  logic [$clog2(PIX_PER_LINE)-1:0]    oq_pix,
  output logic                               oq_pop,
  input  logic                               rf_empty,
  input  logic [PIX_W*PIX_PER_LINE-1:0]      rf_line,
  output logic                               rf_pop,
  output logic                               px_valid,
  output logic [CLIENT_W-1:0]                px_client,
  output logic [PIX_W-1:0]                   px_data
);
  localparam int OFF_W   = $clog2(PIX_PER_LINE);
  localparam int LINE_W  = PIX_W * PIX_PER_LINE;
  localparam int HALF_W  = LINE_W / 2;
  localparam int RADDR_W = SET_W + 1 + OFF_W;

  // named internal events, observed by the bound checker
  logic               go;
  logic               rd_issue, rd_cap, rd_idle, rd_sync, wr_sync;
  logic               mem_we;
  logic [SET_W+1:0]   mem_waddr;
  logic [HALF_W-1:0]  mem_wdata;
  logic [RADDR_W-1:0] rd_addr;

  // an entry may go when present and, for a miss, its line has arrived
  assign go     = rst_n && !oq_empty && (oq_hit || !rf_empty);
  assign oq_pop = rd_sync && wr_sync;

  cos_read_fsm #(.CLIENT_W(CLIENT_W), .RADDR_W(RADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .go(go),
    .client_in(oq_client), .raddr_in({oq_set, oq_way, oq_pix}),
    .peer_sync(wr_sync), .rd_addr(rd_addr), .cap(rd_cap),
    .px_valid(px_valid), .px_client(px_client),
    .issue(rd_issue), .idle(rd_idle), .in_sync(rd_sync)
  );

  cos_write_fsm #(.SET_W(SET_W), .HALF_W(HALF_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .go(go), .miss(!oq_hit),
    .set_in(oq_set), .way_in(oq_way), .line_in(rf_line),
    .peer_sync(rd_sync), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .rf_pop(rf_pop), .in_sync(wr_sync)
  );

  cos_line_store #(.SET_W(SET_W), .OFF_W(OFF_W), .PIX_W(PIX_W), .HALF_W(HALF_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .cap(rd_cap), .rd_pix(px_data)
  );

endmodule

// File: rtl/cos_chk.sv
module cos_chk (
  input logic clk,
  input logic rst_n,
  input logic oq_empty,
  input logic oq_hit,
  input logic rf_empty,
  input logic rf_pop,
  input logic oq_pop,
  input logic px_valid,
  input logic mem_we,
  input logic rd_issue,
  input logic rd_cap,
  input logic rd_idle,
  input logic rd_sync,
  input logic wr_sync
);
  // R6
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !$past(mem_we) |=> mem_we);
  // R6
  we_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |=> !mem_we);
  // R10
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap |-> $past(rd_issue, 2));
  // R10
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sync && !wr_sync |=> rd_sync);
  // R7
  px_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |=> !px_valid);
  // R8
  pop_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> oq_pop);
  // R8
  pop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oq_pop |=> !oq_pop);
  // R4
  rf_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_pop |-> !rf_empty && !oq_empty && !oq_hit);
  // R3
  miss_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idle && !oq_empty && !oq_hit && rf_empty |=> rd_idle);
  // R9
  rf_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oq_empty |-> rf_empty);
endmodule

bind cache_out_seq cos_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oq_empty(oq_empty), .oq_hit(oq_hit),
  .rf_empty(rf_empty), .rf_pop(rf_pop), .oq_pop(oq_pop), .px_valid(px_valid),
  .mem_we(mem_we), .rd_issue(rd_issue), .rd_cap(rd_cap), .rd_idle(rd_idle),
  .rd_sync(rd_sync), .wr_sync(wr_sync)
);

// File: tb/cache_out_seq_tb.sv
`timescale 1ns/1ps
module cache_out_seq_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         oq_empty = 1'b1;
  logic [1:0]   oq_client = '0;
  logic         oq_hit = 1'b0;
  logic [6:0]   oq_set = '0;
  logic         oq_way = 1'b0;
  logic [3:0]   oq_pix = '0;
  logic         oq_pop;
  logic         rf_empty = 1'b1;
  logic [255:0] rf_line = '0;
  logic         rf_pop;
  logic         px_valid;
  logic [1:0]   px_client;
  logic [15:0]  px_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int seed_k = 1;
  logic [255:0] model [256];

  always #2 clk = ~clk;

  cache_out_seq u_dut (
    .clk(clk), .rst_n(rst_n), .oq_empty(oq_empty), .oq_client(oq_client),
    .oq_hit(oq_hit), .oq_set(oq_set), .oq_way(oq_way), .oq_pix(oq_pix),
    .oq_pop(oq_pop), .rf_empty(rf_empty), .rf_line(rf_line), .rf_pop(rf_pop),
    .px_valid(px_valid), .px_client(px_client), .px_data(px_data)
  );

  // {client[18:17], hit[16], set[15:9], way[8], pix[7:4], delay[3:0]}
  localparam logic [18:0] VEC [12] = '{
    {2'd0, 1'b0, 7'd0,   1'b0, 4'd0,  4'd0},
    {2'd1, 1'b1, 7'd0,   1'b0, 4'd15, 4'd0},
    {2'd2, 1'b0, 7'd0,   1'b1, 4'd9,  4'd3},
    {2'd3, 1'b1, 7'd0,   1'b0, 4'd7,  4'd0},
    {2'd0, 1'b1, 7'd0,   1'b1, 4'd3,  4'd0},
    {2'd1, 1'b0, 7'd2,   1'b0, 4'd8,  4'd0},
    {2'd2, 1'b0, 7'd127, 1'b1, 4'd15, 4'd1},
    {2'd3, 1'b1, 7'd127, 1'b1, 4'd0,  4'd0},
    {2'd0, 1'b0, 7'd0,   1'b0, 4'd12, 4'd0},
    {2'd1, 1'b1, 7'd0,   1'b0, 4'd4,  4'd0},
    {2'd2, 1'b1, 7'd2,   1'b0, 4'd15, 4'd0},
    {2'd3, 1'b0, 7'd64,  1'b0, 4'd0,  4'd2}
  };

  function automatic logic [255:0] line_of(input int k);
    logic [255:0] l;
    for (int p = 0; p < 16; p++) l[p*16 +: 16] = 16'(k*97 + p*13 + 1);
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // present one entry at a negedge and follow it until popped
  task automatic run_entry(input logic [18:0] v, input bit hold_rf, input bit keep_open);
    bit hit = v[16];
    int dly = int'(v[3:0]);
    int t = 0, go_t = -1, px_n = 0, px_t = -1;
    bit done = 0;
    logic [255:0] ln = line_of(seed_k);
    logic [15:0] exp_px;
    seed_k++;
    if (!hit) model[{v[15:9], v[8]}] = ln;
    exp_px = model[{v[15:9], v[8]}][int'(v[7:4])*16 +: 16];
    oq_client = v[18:17]; oq_hit = hit; oq_set = v[15:9]; oq_way = v[8]; oq_pix = v[7:4];
    oq_empty = 1'b0;
    rf_line = ln;
    rf_empty = hit ? !hold_rf : (dly != 0);
    if (hit) go_t = 0;
    while (!done) begin
      #1;
      if (!hit && t < dly) begin
        // R3: nothing moves while the line is missing
        chk(!rf_pop && !oq_pop && !px_valid, "R3", "strobe while waiting",
            {rf_pop, oq_pop, px_valid}, 0);
      end
      if (rf_pop) begin
        chk(!hit, "R4", "rf_pop on hit", 1, 0);
        chk(t == dly, "R4", "rf_pop cycle", t, dly);
        go_t = t;
      end
      if (px_valid) begin
        px_n++; px_t = t;
        chk(t == go_t + 3, "R2", "pixel latency", t - go_t, 3);
        chk(px_data == exp_px, "R5", "pixel data", px_data, exp_px);
        chk(px_client == v[18:17], "R7", "client id", px_client, v[18:17]);
      end
      if (oq_pop) begin
        chk(px_valid, "R8", "pop without pixel", px_valid, 1);
        done = 1;
      end
      if (t > 40) begin
        chk(0, "R8", "entry never popped", t, 0);
        done = 1;
      end
      @(negedge clk);
      t++;
      if (!hit && t == dly) rf_empty = 1'b0;
      if (!hit && go_t >= 0) rf_empty = 1'b1;
    end
    chk(px_n == 1, "R7", "pixel count", px_n, 1);
    if (!keep_open) begin
      oq_empty = 1'b1;
      rf_empty = 1'b1;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: entry presented during reset is ignored
    oq_empty = 1'b0; oq_hit = 1'b1; oq_set = 7'd3; oq_pix = 4'd2;
    repeat (4) begin
      @(negedge clk); #1;
      chk(!px_valid && !oq_pop && !rf_pop, "R1", "strobes in reset",
          {px_valid, oq_pop, rf_pop}, 0);
    end
    @(negedge clk);
    oq_empty = 1'b1; rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk); #1;
      chk(!px_valid && !oq_pop && !rf_pop, "R1", "strobes idle queue",
          {px_valid, oq_pop, rf_pop}, 0);
    end
    @(negedge clk);

    // table walk
    for (int i = 0; i < 12; i++) run_entry(VEC[i], 1'b0, 1'b0);

    // R4: hit with refill queue already holding the next miss's line
    run_entry({2'd1, 1'b1, 7'd2, 1'b0, 4'd1, 4'd0}, 1'b1, 1'b1);
    run_entry({2'd2, 1'b0, 7'd3, 1'b1, 4'd10, 4'd0}, 1'b0, 1'b0);
    run_entry({2'd3, 1'b1, 7'd3, 1'b1, 4'd5, 4'd0}, 1'b0, 1'b0);

    // R1: reset partway through a hit aborts it
    oq_client = 2'd2; oq_hit = 1'b1; oq_set = 7'd2; oq_way = 1'b0; oq_pix = 4'd6;
    oq_empty = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; oq_empty = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) begin
      #1;
      chk(!px_valid && !oq_pop, "R1", "aborted entry output", {px_valid, oq_pop}, 0);
      @(negedge clk);
    end
    // recovery, R5: earlier line still in place after reset
    run_entry({2'd0, 1'b1, 7'd2, 1'b0, 4'd6, 4'd0}, 1'b0, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule